// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

This is a passive observer for the command bus of a four-bank SDRAM. It samples the clock enable, the chip select, the three strobes, the bank address and the auto-precharge address bit on every rising clock edge. From these it keeps a model of the device. Each bank is idle, opening (activated, column delay not yet met), open, busy with an auto-precharge burst, or closing (precharge in progress). The model also holds one shared busy window, which follows a refresh or a mode-register write.

Every sampled command is judged against that model. The monitor reports a flag and a code naming the first broken rule. Some codes concern only the addressed bank: a closed row, an unmet column delay, an unmet row-active time, or an auto-precharge lock. Others concern the whole device: the refresh or mode window, a refresh or mode write while any bank is busy, and the wake rule after the clock enable returns. After judging a command, the model advances as if the command had been accepted. Later verdicts therefore follow what a real device would do.

The monitor drives nothing on the bus. It is placed next to a controller or a memory model and watched by a bench or by a scoreboard.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: During and after reset, with no command, `err` is 0 and `err_code` is 0. The verdict for the command sampled at rising edge n appears on `err`/`err_code` after that same edge and holds until the next edge. `err` is 1 exactly when `err_code` is non-zero.
- R2: If `cke` was 0 at the previous edge and is 1 now, any command other than NOP or deselect gives code 1. A deselect or NOP at that edge gives no error.
- R3: After a refresh at edge n, any command other than NOP before edge n+T_RC gives code 2. After a mode write at edge n, the same holds before edge n+T_MRD (2).
- R4: A refresh or mode write while any bank is not idle gives code 4'd3.
- R5: An activate to a bank that is opening, open or closing gives code 4.
- R6: An activate to an idle bank less than T_RRD edges after any earlier activate gives code 5.
- R7: A read or write to an idle or closing bank gives code 6.
- R8: A read or write to a bank less than T_RCD edges after its activate gives code 7.
- R9: A precharge of a single bank (`ap`=0), or a precharge of all banks (`ap`=1), gives code 8 if any targeted open or opening bank was activated less than T_RAS edges earlier.
- R10: While a bank runs a read or write with auto-precharge (`ap`=1), a read, write, activate or precharge that targets it gives code 9. A precharge of all banks counts as targeting it.
- R11: A precharge at edge n makes the bank idle at edge n+T_RP. A read or write with auto-precharge at edge n makes the bank closing at n+AP_HOLD and idle at n+AP_HOLD+T_RP. Legal commands give code 0.
- R12: The code priority is 1, 2, 3, then the per-command rules, with 9 checked before the other checks of that command. Every decoded command updates the model as if accepted, including one that was flagged.
- R13: A command is decoded only when `cke`=1 and `cs_n`=0. The strobes {`ras_n`,`cas_n`,`we_n`} decode as: 000 mode write, 001 refresh, 010 precharge (`ap`=1 for all banks), 011 activate, 100 write, 101 read, 110 burst stop, 111 NOP. `cs_n`=1 is deselect. With `cke`=0 there is no command and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the bus is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | BAW | Bank address |
| ap | input | 1 | Address bit 10: auto-precharge or all-bank select |
| err | output | 1 | Rule violated by the last sampled command |
| err_code | output | 4 | Number of the violated rule, 0 if none |

## Verification
The hardest case to reach is an auto-precharge burst that ends in the middle of other traffic. The bank then has to pass through its closing window and become idle on exactly the right edge. The commands around it must also be judged while counters for other banks and for tRRD are still running.

A directed sequence places a write with auto-precharge between an activate and a precharge on other banks. It then probes the first edge at which the bank accepts a new activate. A long run from a fixed seed follows, mixing commands with clock-enable drops. A cycle-stamped reference model in the bench judges every command of that run.

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor #(
  parameter int NBANK   = 4,
  parameter int BAW     = $clog2(NBANK),
  parameter int T_RCD   = 3,
  parameter int T_RAS   = 6,
  parameter int T_RP    = 3,
  parameter int T_RRD   = 2,
  parameter int T_RC    = 8,
  parameter int T_MRD   = 2,
  parameter int AP_HOLD = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cke,
  input  logic           cs_n,
  input  logic           ras_n,
  input  logic           cas_n,
  input  logic           we_n,
  input  logic [BAW-1:0] ba,
  input  logic           ap,
  output logic           err,
  output logic [3:0]     err_code
);
  localparam int TMAX = T_RCD + T_RAS + T_RP + T_RRD + T_RC + T_MRD + AP_HOLD;
  localparam int CW   = $clog2(TMAX + 1);

  localparam logic [3:0] E_NONE = 4'd0, E_WAKE = 4'd1, E_BUSY = 4'd2, E_NIDLE = 4'd3,
                         E_ACT = 4'd4, E_RRD = 4'd5, E_SHUT = 4'd6, E_RCD = 4'd7,
                         E_RAS = 4'd8, E_APL = 4'd9;

  typedef enum logic [2:0] {B_IDLE, B_OPENING, B_OPEN, B_AUTOPRE, B_CLOSING} bst_t;

  bst_t          st  [NBANK];
  logic [CW-1:0] cnt [NBANK];
  logic [CW-1:0] ras [NBANK];
  logic [CW-1:0] rrd, dev;
  logic          cke_q;
  logic [3:0]    code;

  wire [2:0] op     = {ras_n, cas_n, we_n};
  wire       cmd_on = cke & ~cs_n;
  wire       is_mrs = cmd_on && op == 3'b000;
  wire       is_ref = cmd_on && op == 3'b001;
  wire       is_pre = cmd_on && op == 3'b010;
  wire       is_act = cmd_on && op == 3'b011;
  wire       is_rw  = cmd_on && (op == 3'b100 || op == 3'b101);
  wire       wake   = cmd_on && !cke_q && op != 3'b111;
  bst_t      tgt;
  assign tgt = st[ba];

  logic all_idle, any_ap, any_ras;
  always_comb begin
    all_idle = 1'b1;
    any_ap   = 1'b0;
    any_ras  = 1'b0;
    for (int b = 0; b < NBANK; b++) begin
      if (st[b] != B_IDLE) all_idle = 1'b0;
      if (st[b] == B_AUTOPRE) any_ap = 1'b1;
      if ((st[b] == B_OPENING || st[b] == B_OPEN) && ras[b] != '0) any_ras = 1'b1;
    end
  end

  always_comb begin
    code = E_NONE;
    if (wake) code = E_WAKE;
    else if (cmd_on && op != 3'b111 && dev != '0) code = E_BUSY;
    else if ((is_ref || is_mrs) && !all_idle) code = E_NIDLE;
    else if (is_act) begin
      if (tgt == B_AUTOPRE) code = E_APL;
      else if (tgt != B_IDLE) code = E_ACT;
      else if (rrd != '0) code = E_RRD;
    end else if (is_rw) begin
      if (tgt == B_AUTOPRE) code = E_APL;
      else if (tgt == B_IDLE || tgt == B_CLOSING) code = E_SHUT;
      else if (tgt == B_OPENING) code = E_RCD;
    end else if (is_pre) begin
      if (ap) code = any_ap ? E_APL : (any_ras ? E_RAS : E_NONE);
      else if (tgt == B_AUTOPRE) code = E_APL;
      else if ((tgt == B_OPENING || tgt == B_OPEN) && ras[ba] != '0) code = E_RAS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q    <= 1'b1;
      rrd      <= '0;
      dev      <= '0;
      err      <= 1'b0;
      err_code <= E_NONE;
      for (int b = 0; b < NBANK; b++) begin
        st[b]  <= B_IDLE;
        cnt[b] <= '0;
        ras[b] <= '0;
      end
    end else begin
      cke_q    <= cke;
      err      <= code != E_NONE;
      err_code <= code;
      if (is_act) rrd <= CW'(T_RRD - 1);
      else if (rrd != '0) rrd <= rrd - 1'b1;
      if (is_ref) dev <= CW'(T_RC - 1);
      else if (is_mrs) dev <= CW'(T_MRD - 1);
      else if (dev != '0) dev <= dev - 1'b1;
      for (int b = 0; b < NBANK; b++) begin
        if (is_act && ba == BAW'(b)) ras[b] <= CW'(T_RAS - 1);
        else if (ras[b] != '0) ras[b] <= ras[b] - 1'b1;
        if (is_act && ba == BAW'(b)) begin
          st[b]  <= B_OPENING;
          cnt[b] <= CW'(T_RCD - 1);
        end else if (is_pre && (ap || ba == BAW'(b)) && st[b] inside {B_OPENING, B_OPEN, B_AUTOPRE}) begin
          st[b]  <= B_CLOSING;
          cnt[b] <= CW'(T_RP - 1);
        end else if (is_rw && ap && ba == BAW'(b) && st[b] inside {B_OPENING, B_OPEN, B_AUTOPRE}) begin
          st[b]  <= B_AUTOPRE;
          cnt[b] <= CW'(AP_HOLD - 1);
        end else begin
          case (st[b])
            B_OPENING: if (cnt[b] <= 1) begin st[b] <= B_OPEN; cnt[b] <= '0; end
                       else cnt[b] <= cnt[b] - 1'b1;
            B_AUTOPRE: if (cnt[b] <= 1) begin st[b] <= B_CLOSING; cnt[b] <= CW'(T_RP); end
                       else cnt[b] <= cnt[b] - 1'b1;
            B_CLOSING: if (cnt[b] <= 1) begin st[b] <= B_IDLE; cnt[b] <= '0; end
                       else cnt[b] <= cnt[b] - 1'b1;
            default:   cnt[b] <= '0;
          endcase
        end
      end
    end
  end

  p_wake_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (err && err_code == 4'd1));

  p_busy_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_on && cke_q && op != 3'b111 && dev != '0) |=> (err_code == 4'd2));

  p_act_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act && cke_q && dev == '0 && tgt == B_IDLE && rrd != '0) |=> (err_code == 4'd5));

  p_col_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rw && cke_q && dev == '0 && tgt == B_OPENING) |=> (err_code == 4'd7));

  p_quiet_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> !err);
endmodule

// File: tb/test_sdram_cmd_monitor.sv
module test_sdram_cmd_monitor;
  localparam int T_RCD = 3, T_RAS = 6, T_RP = 3, T_RRD = 2, T_RC = 8, T_MRD = 2, AP_HOLD = 4;
  localparam logic [2:0] MRS = 3'd0, REF = 3'd1, PRE = 3'd2, ACT = 3'd3,
                         WR = 3'd4, RD = 3'd5, BST = 3'd6, NOP = 3'd7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, ap = 1'b0;
  logic [1:0] ba = 2'd0;
  logic err;
  logic [3:0] err_code;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  sdram_cmd_monitor i_sdram_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .ap(ap), .err(err), .err_code(err_code));

  bit     m_open [4];
  bit     m_ap   [4];
  longint m_act  [4];
  longint m_apt  [4];
  longint m_pre  [4];
  longint last_act = -100, dev_ready = 0, now = 0;
  bit     kprev = 1'b1;

  function automatic string req_tag(input logic [3:0] c);
    case (c)
      4'd1: return "R2";  4'd2: return "R3";  4'd3: return "R4";
      4'd4: return "R5";  4'd5: return "R6";  4'd6: return "R7";
      4'd7: return "R8";  4'd8: return "R9";  4'd9: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic bit m_idle(input int b);
    return !m_open[b] && now >= m_pre[b];
  endfunction

  task automatic settle();
    for (int b = 0; b < 4; b++)
      if (m_ap[b] && now >= m_apt[b]) begin
        m_ap[b] = 0; m_open[b] = 0; m_pre[b] = m_apt[b] + T_RP;
      end
  endtask

  function automatic logic [3:0] model_code(input bit k, input bit cs, input logic [2:0] o,
                                            input int b, input bit a);
    bit anyap = 0, anyras = 0, allidle = 1;
    if (!k || cs || o == NOP) return 4'd0;
    if (!kprev) return 4'd1;
    if (now < dev_ready) return 4'd2;
    for (int i = 0; i < 4; i++) begin
      if (m_ap[i]) anyap = 1;
      if (m_open[i] && now < m_act[i] + T_RAS) anyras = 1;
      if (!m_idle(i)) allidle = 0;
    end
    case (o)
      MRS, REF: return allidle ? 4'd0 : 4'd3;
      ACT: begin
        if (m_ap[b]) return 4'd9;
        if (!m_idle(b)) return 4'd4;
        if (now < last_act + T_RRD) return 4'd5;
      end
      RD, WR: begin
        if (m_ap[b]) return 4'd9;
        if (!m_open[b]) return 4'd6;
        if (now < m_act[b] + T_RCD) return 4'd7;
      end
      PRE: begin
        if (a) return anyap ? 4'd9 : (anyras ? 4'd8 : 4'd0);
        if (m_ap[b]) return 4'd9;
        if (m_open[b] && now < m_act[b] + T_RAS) return 4'd8;
      end
      default: ;
    endcase
    return 4'd0;
  endfunction

  task automatic model_update(input bit k, input bit cs, input logic [2:0] o, input int b, input bit a);
    kprev = k;
    if (!k || cs) return;
    case (o)
      ACT: begin m_open[b] = 1; m_ap[b] = 0; m_act[b] = now; last_act = now; end
      RD, WR: if (a && m_open[b]) begin m_ap[b] = 1; m_apt[b] = now + AP_HOLD; end
      PRE: for (int i = 0; i < 4; i++)
             if ((a || i == b) && m_open[i]) begin m_open[i] = 0; m_ap[i] = 0; m_pre[i] = now + T_RP; end
      REF: dev_ready = now + T_RC;
      MRS: dev_ready = now + T_MRD;
      default: ;
    endcase
  endtask

  task automatic check(input logic [3:0] e, input string tag);
    total++;
    if (err !== (e != 0) || err_code !== e) begin
      bad++;
      $display("FAIL %s at step %0d: err=%0b code=%0d expected err=%0b code=%0d",
               tag, now, err, err_code, (e != 0), e);
    end
  endtask

  task automatic step(input bit k, input bit cs, input logic [2:0] o, input logic [1:0] b,
                      input bit a, input int exp, input string tag);
    logic [3:0] e;
    cke = k; cs_n = cs; {ras_n, cas_n, we_n} = o; ba = b; ap = a;
    settle();
    e = model_code(k, cs, o, int'(b), a);
    if (exp >= 0) e = 4'(exp);
    model_update(k, cs, o, int'(b), a);
    @(posedge clk);
    @(negedge clk);
    check(e, (tag == "") ? req_tag(e) : tag);
    now++;
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed = $urandom(32'd4242);
    for (int b = 0; b < 4; b++) begin m_open[b] = 0; m_ap[b] = 0; m_act[b] = -100; m_pre[b] = 0; m_apt[b] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(4'd0, "R1");
    rst_n = 1'b1;
    step(1, 0, ACT, 0, 0, 0, "R11");
    step(1, 0, ACT, 1, 0, 5, "R6");
    step(1, 0, RD,  0, 0, 7, "R8");
    step(1, 0, RD,  0, 0, 0, "R8");
    step(1, 0, ACT, 0, 0, 4, "R5");
    step(1, 0, PRE, 0, 0, 8, "R9");
    step(1, 0, RD,  0, 0, 6, "R7");
    step(1, 0, ACT, 2, 0, 0, "R6");
    step(1, 0, REF, 0, 0, 3, "R4");
    step(1, 0, NOP, 0, 0, 0, "R3");
    step(1, 0, RD,  1, 0, 2, "R3");
    for (int i = 0; i < 5; i++) step(1, 0, NOP, 0, 0, 0, "R3");
    step(1, 0, RD,  1, 0, 0, "R3");
    step(1, 0, WR,  2, 1, 0, "R11");
    step(1, 0, RD,  2, 0, 9, "R10");
    step(1, 0, PRE, 1, 0, 0, "R9");
    step(1, 0, NOP, 0, 0, 0, "R11");
    step(1, 0, NOP, 0, 0, 0, "R11");
    step(1, 0, ACT, 1, 0, 0, "R11");
    step(1, 0, NOP, 0, 0, 0, "R11");
    step(1, 0, ACT, 2, 0, 0, "R11");
    step(1, 0, PRE, 0, 1, 8, "R9");
    step(1, 0, NOP, 0, 0, 0, "R11");
    step(1, 0, NOP, 0, 0, 0, "R11");
    step(1, 0, MRS, 0, 0, 0, "R4");
    step(1, 0, ACT, 0, 0, 2, "R3");
    step(1, 0, ACT, 3, 0, 5, "R12");
    step(0, 0, ACT, 1, 0, 0, "R13");
    step(1, 0, RD,  0, 0, 1, "R2");
    step(0, 0, NOP, 0, 0, 0, "R13");
    step(1, 1, ACT, 0, 0, 0, "R2");
    step(1, 0, RD,  0, 0, 0, "R13");
    step(1, 0, BST, 0, 0, 0, "R13");
    for (int i = 0; i < 4000; i++) begin
      int unsigned r = $urandom % 100;
      bit k = ($urandom % 100) >= 5;
      bit cs = ($urandom % 100) < 10;
      logic [2:0] o;
      if (r < 40) o = NOP;
      else if (r < 43) o = REF;
      else if (r < 45) o = MRS;
      else o = 3'(2 + ($urandom % 5));
      step(k, cs, o, 2'($urandom % 4), 1'($urandom % 2), -1, "");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule